// File: doc/BRIEF.md
# I2C Master NACK Stall and DMA Request Control

This block sits next to an I2C byte engine that can act as master or slave. It drives the data register's DMA requests. In transmit direction it asks for a byte while the register is empty. In receive direction it asks for service while the register holds a byte. After each DMA access it withdraws the request, so one byte never produces two transfers.

In master receiver operation with DMA, software loads a count of the bytes it expects. Each DMA read of the data register lowers that count. When only one byte is left, the block can switch the acknowledge select to NACK on its own, which ends the read cleanly. A NACK that the block generates itself is never reported as a received NACK.

When the master receives a NACK, whether in an address frame or a data frame, the block holds SCL low. The hold lasts until software writes a new target address or asks for STOP. A sticky status flag records the received NACK until software clears it.

Top module: `i2c_nack_dma_ctrl`

## Requirements
- R1: `tx_dma_req_o` is 1 only while `rx_mode_i`=0 (transmit), `tx_dma_en_i`=1 and `dr_empty_i`=1, and no write is still awaiting a drop of `dr_empty_i`. Otherwise it is 0. The output is combinational in these inputs.
- R2: `rx_dma_req_o` is 1 only while `rx_mode_i`=1 (receive), `rx_dma_en_i`=1 and `dr_full_i`=1, and no read is still awaiting a drop of `dr_full_i`. Otherwise it is 0.
- R3: In the cycle after `dr_wr_i` is sampled high, `tx_dma_req_o` is 0. It stays 0 until `dr_empty_i` has been sampled low at least once.
- R4: In the cycle after `dr_rd_i` is sampled high, `rx_dma_req_o` is 0. It stays 0 until `dr_full_i` has been sampled low at least once.
- R5: `cnt_load_i` loads `cnt_val_i` into `cnt_o` on the next edge, and a load takes priority over a decrement. A `dr_rd_i` pulse lowers the count by one only while `master_i`=1, `rx_mode_i`=1 and `rx_dma_en_i`=1. The count stops at zero.
- R6: `nack_o` (1 = NACK, 0 = ACK) is 1 exactly when `master_i`, `rx_mode_i`, `rx_dma_en_i` and `dma_nack_en_i` are all 1 and `cnt_o` equals 1.
- R7: A NACK qualifies when `nack_rx_i`=1 and either `addr_phase_i`=1 or `rx_mode_i`=0. A qualifying NACK while `master_i`=1 sets `scl_hold_o` on the next edge.
- R8: `scl_hold_o` clears on the edge after `tar_wr_i` or `stop_req_i` is sampled high, and this release wins over a NACK in the same cycle. No other input clears it.
- R9: `nack_rx_i` during a master receiver data frame (`master_i`=1, `rx_mode_i`=1, `addr_phase_i`=0) is the block's own NACK. It sets neither `nack_flag_o` nor `scl_hold_o`.
- R10: `nack_flag_o` is set on the edge after any qualifying NACK, in master or slave mode. It stays set until `nack_clr_i` is sampled high. A set in the same cycle wins over the clear.
- R11: A qualifying NACK with `master_i`=0 sets `nack_flag_o` but leaves `scl_hold_o` at 0.
- R12: After reset all outputs are 0 and `cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = engine acts as master |
| rx_mode_i | input | 1 | 0 = transmit, 1 = receive |
| addr_phase_i | input | 1 | Current frame is the address frame |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| dma_nack_en_i | input | 1 | Allow automatic NACK on the final DMA byte |
| dr_empty_i | input | 1 | Data register empty (transmit) |
| dr_full_i | input | 1 | Data register holds a byte (receive) |
| dr_wr_i | input | 1 | Strobe: data register written |
| dr_rd_i | input | 1 | Strobe: data register read by DMA |
| cnt_load_i | input | 1 | Strobe: load the byte count |
| cnt_val_i | input | CNT_W | Byte count to load |
| nack_rx_i | input | 1 | Strobe: NACK seen on the bus at the ack slot |
| tar_wr_i | input | 1 | Strobe: new target address written |
| stop_req_i | input | 1 | Strobe: STOP requested |
| nack_clr_i | input | 1 | Write-one-to-clear strobe for the NACK flag |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| nack_o | output | 1 | Acknowledge select, 1 = NACK |
| scl_hold_o | output | 1 | Hold SCL low |
| nack_flag_o | output | 1 | Sticky NACK-received flag |
| cnt_o | output | CNT_W | Remaining byte count |

## Verification
The assertions assume that every strobe (`dr_wr_i`, `dr_rd_i`, `cnt_load_i`, `nack_rx_i`, `tar_wr_i`, `stop_req_i`, `nack_clr_i`) is a single-cycle pulse, and that the engine drops `dr_empty_i` or `dr_full_i` soon after a DMA access. The request rules only hold while those register status levels behave like a real register. The bench changes inputs only on falling edges, pulses each strobe for exactly one cycle, and models the register status dropping after each access. Mode inputs change only between transfers, never in the same cycle as a NACK strobe.

// File: rtl/i2c_nd_pkg.sv
package i2c_nd_pkg;
  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic      master;
    xfer_dir_e dir;
    logic      addr_phase;
  } bus_ctx_t;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_TX    = 0;
  localparam int unsigned CH_RX    = 1;
endpackage

// File: rtl/i2c_nd_dma_chan.sv
module i2c_nd_dma_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic level_i,
  input  logic strobe_i,
  output logic req_o
);
  logic pend_q;

  // one access per status assertion: wait for the level to drop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (strobe_i)   pend_q <= 1'b1;
    else if (!level_i)   pend_q <= 1'b0;
  end

  assign req_o = active_i & level_i & ~pend_q;
endmodule

// File: rtl/i2c_nd_byte_cnt.sv
module i2c_nd_byte_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (dec_i && !zero) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/i2c_nd_nack_hold.sv
module i2c_nd_nack_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic nack_i,
  input  logic release_i,
  input  logic clr_i,
  output logic hold_o,
  output logic flag_o
);
  logic hold_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_q <= 1'b0;
    else if (release_i)           hold_q <= 1'b0;
    else if (master_i && nack_i)  hold_q <= 1'b1;
  end

  // set beats clear so a NACK is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (nack_i)  flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign hold_o = hold_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_nack_dma_ctrl.sv
module i2c_nack_dma_ctrl
  import i2c_nd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             rx_mode_i,
  input  logic             addr_phase_i,
  input  logic             tx_dma_en_i,
  input  logic             rx_dma_en_i,
  input  logic             dma_nack_en_i,
  input  logic             dr_empty_i,
  input  logic             dr_full_i,
  input  logic             dr_wr_i,
  input  logic             dr_rd_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             nack_rx_i,
  input  logic             tar_wr_i,
  input  logic             stop_req_i,
  input  logic             nack_clr_i,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o,
  output logic             nack_o,
  output logic             scl_hold_o,
  output logic             nack_flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  bus_ctx_t ctx;
  assign ctx.master     = master_i;
  assign ctx.dir        = xfer_dir_e'(rx_mode_i);
  assign ctx.addr_phase = addr_phase_i;

  logic mst_rx_dma;
  assign mst_rx_dma = ctx.master && (ctx.dir == XFER_RX) && rx_dma_en_i;

  logic [NUM_CHAN-1:0] ch_active, ch_level, ch_strobe, ch_req;

  assign ch_active[CH_TX] = (ctx.dir == XFER_TX) && tx_dma_en_i;
  assign ch_level[CH_TX]  = dr_empty_i;
  assign ch_strobe[CH_TX] = dr_wr_i;
  assign ch_active[CH_RX] = (ctx.dir == XFER_RX) && rx_dma_en_i;
  assign ch_level[CH_RX]  = dr_full_i;
  assign ch_strobe[CH_RX] = dr_rd_i;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    i2c_nd_dma_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (ch_active[g]),
      .level_i  (ch_level[g]),
      .strobe_i (ch_strobe[g]),
      .req_o    (ch_req[g])
    );
  end

  assign tx_dma_req_o = ch_req[CH_TX];
  assign rx_dma_req_o = ch_req[CH_RX];

  logic last_byte;

  i2c_nd_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load_i),
    .val_i  (cnt_val_i),
    .dec_i  (dr_rd_i && mst_rx_dma),
    .cnt_o  (cnt_o),
    .last_o (last_byte)
  );

  assign nack_o = mst_rx_dma && dma_nack_en_i && last_byte;

  // a NACK in a master-receiver data frame is our own
  logic nack_qual;
  assign nack_qual = nack_rx_i && (ctx.addr_phase || (ctx.dir == XFER_TX));

  i2c_nd_nack_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .master_i  (ctx.master),
    .nack_i    (nack_qual),
    .release_i (tar_wr_i || stop_req_i),
    .clr_i     (nack_clr_i),
    .hold_o    (scl_hold_o),
    .flag_o    (nack_flag_o)
  );
endmodule

// File: rtl/i2c_nack_dma_ctrl_chk.sv
module i2c_nack_dma_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_i,
  input logic             rx_mode_i,
  input logic             addr_phase_i,
  input logic             tx_dma_en_i,
  input logic             rx_dma_en_i,
  input logic             dma_nack_en_i,
  input logic             dr_empty_i,
  input logic             dr_full_i,
  input logic             dr_wr_i,
  input logic             dr_rd_i,
  input logic             cnt_load_i,
  input logic [CNT_W-1:0] cnt_val_i,
  input logic             nack_rx_i,
  input logic             tar_wr_i,
  input logic             stop_req_i,
  input logic             nack_clr_i,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o,
  input logic             nack_o,
  input logic             scl_hold_o,
  input logic             nack_flag_o,
  input logic [CNT_W-1:0] cnt_o
);
  a_r1_tx_req_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (!rx_mode_i && tx_dma_en_i && dr_empty_i));

  a_r2_rx_req_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_mode_i && rx_dma_en_i && dr_full_i));

  a_r3_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_wr_i |=> !tx_dma_req_o);

  a_r4_rx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_rd_i |=> !rx_dma_req_o);

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> (cnt_o == $past(cnt_val_i)));

  a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !cnt_load_i) |=> (cnt_o == '0));

  a_r6_nack_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> (master_i && rx_mode_i && rx_dma_en_i && dma_nack_en_i && cnt_o == CNT_W'(1)));

  a_r7_hold_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && nack_rx_i && (addr_phase_i || !rx_mode_i) && !tar_wr_i && !stop_req_i)
      |=> scl_hold_o);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tar_wr_i || stop_req_i) |=> !scl_hold_o);

  a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !tar_wr_i && !stop_req_i) |=> scl_hold_o);

  a_r9_self_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_rx_i && master_i && rx_mode_i && !addr_phase_i && !nack_flag_o) |=> !nack_flag_o);

  a_r10_flag_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_flag_o && !nack_clr_i) |=> nack_flag_o);

  a_r11_slave_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && !scl_hold_o) |=> !scl_hold_o);
endmodule

bind i2c_nack_dma_ctrl i2c_nack_dma_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .rx_mode_i(rx_mode_i),
  .addr_phase_i(addr_phase_i), .tx_dma_en_i(tx_dma_en_i), .rx_dma_en_i(rx_dma_en_i),
  .dma_nack_en_i(dma_nack_en_i), .dr_empty_i(dr_empty_i), .dr_full_i(dr_full_i),
  .dr_wr_i(dr_wr_i), .dr_rd_i(dr_rd_i), .cnt_load_i(cnt_load_i), .cnt_val_i(cnt_val_i),
  .nack_rx_i(nack_rx_i), .tar_wr_i(tar_wr_i), .stop_req_i(stop_req_i),
  .nack_clr_i(nack_clr_i), .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o),
  .nack_o(nack_o), .scl_hold_o(scl_hold_o), .nack_flag_o(nack_flag_o), .cnt_o(cnt_o)
);

// File: tb/i2c_nack_dma_ctrl_test.sv
module i2c_nack_dma_ctrl_test;
  localparam int unsigned CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 0, rx_mode_i = 0, addr_phase_i = 0;
  logic tx_dma_en_i = 0, rx_dma_en_i = 0, dma_nack_en_i = 0;
  logic dr_empty_i = 0, dr_full_i = 0, dr_wr_i = 0, dr_rd_i = 0;
  logic cnt_load_i = 0;
  logic [CNT_W-1:0] cnt_val_i = '0;
  logic nack_rx_i = 0, tar_wr_i = 0, stop_req_i = 0, nack_clr_i = 0;
  logic tx_dma_req_o, rx_dma_req_o, nack_o, scl_hold_o, nack_flag_o;
  logic [CNT_W-1:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  i2c_nack_dma_ctrl #(.CNT_W(CNT_W)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one edge; strobes are one-cycle pulses
  task automatic tick();
    @(negedge clk_i);
    dr_wr_i = 0; dr_rd_i = 0; cnt_load_i = 0; nack_rx_i = 0;
    tar_wr_i = 0; stop_req_i = 0; nack_clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R12 tx req", tx_dma_req_o, 0);
    chk("R12 rx req", rx_dma_req_o, 0);
    chk("R12 nack", nack_o, 0);
    chk("R12 hold", scl_hold_o, 0);
    chk("R12 flag", nack_flag_o, 0);
    chk("R12 cnt", cnt_o, 0);
  endtask

  task automatic t_tx_req();
    rx_mode_i = 0; tx_dma_en_i = 1; dr_empty_i = 1; #1;
    chk("R1 tx req on", tx_dma_req_o, 1);
    tx_dma_en_i = 0; #1;
    chk("R1 tx req disabled", tx_dma_req_o, 0);
    tx_dma_en_i = 1; rx_mode_i = 1; #1;
    chk("R1 tx req in rx mode", tx_dma_req_o, 0);
    rx_mode_i = 0; dr_wr_i = 1;
    tick();
    chk("R3 drop after write", tx_dma_req_o, 0);
    tick();
    chk("R3 still low while empty", tx_dma_req_o, 0);
    dr_empty_i = 0;
    tick();
    dr_empty_i = 1; #1;
    chk("R3 rearmed", tx_dma_req_o, 1);
    tx_dma_en_i = 0; dr_empty_i = 0;
    tick();
  endtask

  task automatic t_rx_req();
    master_i = 0; rx_mode_i = 1; rx_dma_en_i = 1; dr_full_i = 1; #1;
    chk("R2 rx req on", rx_dma_req_o, 1);
    rx_dma_en_i = 0; #1;
    chk("R2 rx req disabled", rx_dma_req_o, 0);
    rx_dma_en_i = 1; dr_rd_i = 1;
    tick();
    chk("R4 drop after read", rx_dma_req_o, 0);
    dr_full_i = 0;
    tick();
    dr_full_i = 1; #1;
    chk("R4 rearmed", rx_dma_req_o, 1);
    dr_full_i = 0; rx_dma_en_i = 0;
    tick();
  endtask

  task automatic t_count();
    master_i = 1; rx_mode_i = 1; rx_dma_en_i = 1; dma_nack_en_i = 1;
    cnt_load_i = 1; cnt_val_i = 3;
    tick();
    chk("R5 load", cnt_o, 3);
    chk("R6 ack while 3 left", nack_o, 0);
    dr_rd_i = 1;
    tick();
    chk("R5 dec to 2", cnt_o, 2);
    dr_rd_i = 1;
    tick();
    chk("R5 dec to 1", cnt_o, 1);
    chk("R6 auto nack at 1", nack_o, 1);
    dma_nack_en_i = 0; #1;
    chk("R6 no nack when disabled", nack_o, 0);
    dma_nack_en_i = 1; master_i = 0; #1;
    chk("R6 no nack as slave", nack_o, 0);
    master_i = 1;
    dr_rd_i = 1;
    tick();
    chk("R5 dec to 0", cnt_o, 0);
    chk("R6 ack at 0", nack_o, 0);
    dr_rd_i = 1;
    tick();
    chk("R5 floor at 0", cnt_o, 0);
    cnt_load_i = 1; cnt_val_i = 5; dr_rd_i = 1;
    tick();
    chk("R5 load beats dec", cnt_o, 5);
    rx_dma_en_i = 0; dr_rd_i = 1;
    tick();
    chk("R5 no dec without dma", cnt_o, 5);
    dma_nack_en_i = 0;
  endtask

  task automatic t_hold_tx();
    master_i = 1; rx_mode_i = 0; addr_phase_i = 0; nack_rx_i = 1;
    tick();
    chk("R7 hold on tx nack", scl_hold_o, 1);
    chk("R10 flag set", nack_flag_o, 1);
    tick(); tick();
    chk("R8 hold persists", scl_hold_o, 1);
    nack_clr_i = 1;
    tick();
    chk("R10 flag cleared", nack_flag_o, 0);
    chk("R8 clear does not release", scl_hold_o, 1);
    tar_wr_i = 1;
    tick();
    chk("R8 released by address write", scl_hold_o, 0);
    nack_rx_i = 1;
    tick();
    stop_req_i = 1;
    tick();
    chk("R8 released by stop", scl_hold_o, 0);
    nack_rx_i = 1; stop_req_i = 1;
    tick();
    chk("R8 release beats set", scl_hold_o, 0);
    nack_rx_i = 1; nack_clr_i = 1;
    tick();
    chk("R10 set beats clear", nack_flag_o, 1);
    nack_clr_i = 1;
    tick();
  endtask

  task automatic t_hold_addr();
    master_i = 1; rx_mode_i = 1; addr_phase_i = 1; nack_rx_i = 1;
    tick();
    chk("R7 hold on address nack in rx", scl_hold_o, 1);
    stop_req_i = 1; nack_clr_i = 1;
    tick();
    chk("R8 stop release", scl_hold_o, 0);
  endtask

  task automatic t_self_nack();
    master_i = 1; rx_mode_i = 1; addr_phase_i = 0; nack_rx_i = 1;
    tick();
    chk("R9 no flag on own nack", nack_flag_o, 0);
    chk("R9 no hold on own nack", scl_hold_o, 0);
  endtask

  task automatic t_slave();
    master_i = 0; rx_mode_i = 0; nack_rx_i = 1;
    tick();
    chk("R11 slave flag", nack_flag_o, 1);
    chk("R11 slave no hold", scl_hold_o, 0);
    nack_clr_i = 1;
    tick();
    chk("R10 slave flag cleared", nack_flag_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    tick();
    t_tx_req();
    t_rx_req();
    t_count();
    t_hold_tx();
    t_hold_addr();
    t_self_nack();
    t_slave();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule